// File: doc/BRIEF.md
# Region-Partitioned Pseudo-LRU Victim Selector

This block picks the way to replace in one set of a set-associative cache (eight ways by default). Each set keeps a binary pseudo-LRU tree, and the tree walk is steered by an eligibility mask. The mask depends on the class of the allocation. Some ways can be reserved for use as SRAM, and these are never returned. A configurable group of ways can be set aside for stashed I/O data. When that group is enabled, I/O stash fills and processor fills never displace each other's lines. Every set is partitioned in the same way, so each set holds both regions in separate ways.

The cache controller presents a set index and a request class, and reads the victim way in the same cycle. For every hit or fill it pulses an update strobe with the set and the way. The tree of that set then moves away from the touched way. The change is visible from the next cycle on. Tag compare, data arrays and write-back are handled outside this block.

Top module: `way_plru_victim`

## Requirements
- R1: After a synchronous active-high reset every set's tree is cleared. With all ways eligible, every set then returns victim way 0 and `no_way` low.
- R2: For a processor request (`req_stash`=0), the eligible ways are those whose bit is clear in `sram_ways`. When `stash_on`=1, the bit must also be clear in `stash_ways`. The victim is always one of these ways.
- R3: For a stash request (`req_stash`=1) with `stash_on`=1, the eligible ways are those set in `stash_ways` and clear in `sram_ways`. The victim is one of them.
- R4: When `stash_on`=0, a stash request uses the same eligibility as a processor request.
- R5: Tree encoding: the root node decides way bit 2, its children decide bit 1, and the third level decides bit 0. A node value of 0 points to the lower-numbered half. At each node the walk follows the pointer if that half holds an eligible way, and otherwise takes the other half.
- R6: An update strobe on way w rewrites every node on w's path so that it points away from w. The new tree is seen by the victim output from the cycle after the strobe, and not in the strobe cycle.
- R7: An update changes only the tree of the addressed set.
- R8: If no way is eligible, `no_way` is 1 and the victim is way 0.
- R9: The victim and `no_way` follow `lookup_set`, the request class and the masks in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookup_set | input | SET_W | Set whose victim is requested |
| req_stash | input | 1 | 1 = stashed I/O allocation, 0 = processor allocation |
| sram_ways | input | WAYS | Ways reserved as SRAM |
| stash_ways | input | WAYS | Ways forming the stash-only region |
| stash_on | input | 1 | Enables the stash-only region |
| upd_valid | input | 1 | Access (hit or fill) strobe |
| upd_set | input | SET_W | Set of the access |
| upd_way | input | WAY_W | Way of the access |
| victim_way | output | WAY_W | Selected victim way |
| no_way | output | 1 | No eligible way for this request |

## Verification
The bench builds the block with eight ways and four sets. This is small enough to sweep all 256 SRAM reservation masks against several stash-region masks, both request classes and both settings of the stash enable. Each sweep is repeated at many tree states, which are reached by pseudo-random access sequences over all sets. A fixed access order checks the tree encoding against known victims. Per-set isolation and the one-cycle update latency are checked directly at the ports.

// File: rtl/plru_pkg.sv
package plru_pkg;
  typedef enum logic {CLS_CPU = 1'b0, CLS_STASH = 1'b1} alloc_cls_e;
endpackage

// File: rtl/plru_region_mask.sv
module plru_region_mask #(
  parameter int WAYS = 8
) (
  input  logic            req_stash,
  input  logic [WAYS-1:0] sram_ways,
  input  logic [WAYS-1:0] stash_ways,
  input  logic            stash_on,
  output logic [WAYS-1:0] elig
);
  import plru_pkg::*;
  logic [WAYS-1:0] cpu_set;
  logic [WAYS-1:0] io_set;
  alloc_cls_e      cls;

  assign cls     = alloc_cls_e'(req_stash);
  assign cpu_set = ~sram_ways & ~(stash_on ? stash_ways : '0);
  assign io_set  = stash_on ? (stash_ways & ~sram_ways) : cpu_set;
  assign elig    = (cls == CLS_STASH) ? io_set : cpu_set;
endmodule

// File: rtl/plru_tree_walk.sv
module plru_tree_walk #(
  parameter int WAYS  = 8,
  localparam int LVL   = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] tree,
  input  logic [WAYS-1:0]  elig,
  output logic [LVL-1:0]   way,
  output logic             none
);
  logic [LVL-1:0] path;

  always_comb begin
    int  pre;
    int  node;
    logic lany;
    logic rany;
    path = '0;
    for (int l = 0; l < LVL; l++) begin
      pre  = int'(path) >> (LVL - l);
      node = (1 << l) + pre;
      lany = 1'b0;
      rany = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if ((w >> (LVL - l)) == pre) begin
          if (((w >> (LVL - 1 - l)) & 1) == 0) lany = lany | elig[w];
          else                                 rany = rany | elig[w];
        end
      end
      path[LVL-1-l] = tree[node-1] ? rany : ~lany;
    end
  end

  assign none = ~|elig;
  assign way  = none ? '0 : path;
endmodule

// File: rtl/plru_tree_store.sv
module plru_tree_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  localparam int LVL   = $clog2(WAYS),
  localparam int NODES = WAYS - 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic [NODES-1:0] rd_tree,
  input  logic             upd_valid,
  input  logic [SET_W-1:0] upd_set,
  input  logic [LVL-1:0]   upd_way
);
  logic [NODES-1:0] mem [SETS];
  logic [NODES-1:0] nxt;

  assign rd_tree = mem[rd_set];

  always_comb begin
    int pre;
    nxt = mem[upd_set];
    for (int l = 0; l < LVL; l++) begin
      pre = int'(upd_way) >> (LVL - l);
      nxt[(1 << l) + pre - 1] = ~upd_way[LVL-1-l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) mem[s] <= '0;
    end else if (upd_valid) begin
      mem[upd_set] <= nxt;
    end
  end
endmodule

// File: rtl/way_plru_victim.sv
module way_plru_victim #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  localparam int LVL   = $clog2(WAYS),
  localparam int NODES = WAYS - 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lookup_set,
  input  logic             req_stash,
  input  logic [WAYS-1:0]  sram_ways,
  input  logic [WAYS-1:0]  stash_ways,
  input  logic             stash_on,
  input  logic             upd_valid,
  input  logic [SET_W-1:0] upd_set,
  input  logic [LVL-1:0]   upd_way,
  output logic [LVL-1:0]   victim_way,
  output logic             no_way
);
  logic [WAYS-1:0]  elig;
  logic [NODES-1:0] cur_tree;

  plru_region_mask #(.WAYS(WAYS)) u_mask (
    .req_stash (req_stash),
    .sram_ways (sram_ways),
    .stash_ways(stash_ways),
    .stash_on  (stash_on),
    .elig      (elig)
  );

  plru_tree_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_set   (lookup_set),
    .rd_tree  (cur_tree),
    .upd_valid(upd_valid),
    .upd_set  (upd_set),
    .upd_way  (upd_way)
  );

  plru_tree_walk #(.WAYS(WAYS)) u_walk (
    .tree(cur_tree),
    .elig(elig),
    .way (victim_way),
    .none(no_way)
  );
endmodule

// File: rtl/way_plru_victim_chk.sv
module way_plru_victim_chk #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  localparam int LVL   = $clog2(WAYS),
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [SET_W-1:0] lookup_set,
  input logic             req_stash,
  input logic [WAYS-1:0]  sram_ways,
  input logic [WAYS-1:0]  stash_ways,
  input logic             stash_on,
  input logic             upd_valid,
  input logic [SET_W-1:0] upd_set,
  input logic [LVL-1:0]   upd_way,
  input logic [LVL-1:0]   victim_way,
  input logic             no_way
);
  logic [WAYS-1:0] cpu_ok;
  logic [WAYS-1:0] io_ok;
  logic [WAYS-1:0] req_ok;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cpu_ok[w] = !sram_ways[w] && !(stash_on && stash_ways[w]);
      io_ok[w]  = stash_on ? (stash_ways[w] && !sram_ways[w]) : cpu_ok[w];
    end
    req_ok = req_stash ? io_ok : cpu_ok;
  end

  a_r2_cpu_region: assert property (@(posedge clk) disable iff (rst)
    (!req_stash && !no_way) |-> cpu_ok[victim_way]);

  a_r3_stash_region: assert property (@(posedge clk) disable iff (rst)
    (req_stash && stash_on && !no_way) |-> (stash_ways[victim_way] && !sram_ways[victim_way]));

  a_r8_empty_way0: assert property (@(posedge clk) disable iff (rst)
    no_way |-> (victim_way == '0));

  a_r8_empty_flag: assert property (@(posedge clk) disable iff (rst)
    (req_ok == '0) == no_way);

  a_r6_moves_away: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_valid) && lookup_set == $past(upd_set) && $countones(req_ok) > 1)
      |-> (victim_way != $past(upd_way)));
endmodule

bind way_plru_victim way_plru_victim_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (.*);

// File: tb/way_plru_victim_test.sv
module way_plru_victim_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4;
  localparam int WAYS = 8;

  logic       clk = 0;
  logic       rst = 1;
  logic [1:0] lookup_set = 0;
  logic       req_stash = 0;
  logic [7:0] sram_ways = 0;
  logic [7:0] stash_ways = 0;
  logic       stash_on = 0;
  logic       upd_valid = 0;
  logic [1:0] upd_set = 0;
  logic [2:0] upd_way = 0;
  logic [2:0] victim_way;
  logic       no_way;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit [6:0] mt [SETS];
  logic [15:0] lfsr = 16'hACE1;

  way_plru_victim #(.SETS(SETS), .WAYS(WAYS)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model: leaf of way w is heap node 8+w; node k stored at bit k-1.
  function automatic int mvict(bit [6:0] t, bit [7:0] e);
    int node = 1;
    if (e == 0) return -1;
    for (int l = 0; l < 3; l++) begin
      bit lany = 0, rany = 0;
      for (int w = 0; w < 8; w++) begin
        if (((8 + w) >> (2 - l)) == 2 * node)     lany |= e[w];
        if (((8 + w) >> (2 - l)) == 2 * node + 1) rany |= e[w];
      end
      if (t[node-1]) node = rany ? 2 * node + 1 : 2 * node;
      else           node = lany ? 2 * node : 2 * node + 1;
    end
    return node - 8;
  endfunction

  function automatic bit [6:0] mupd(bit [6:0] t, int w);
    for (int l = 0; l < 3; l++) begin
      int anc = (8 + w) >> (3 - l);
      int kid = (8 + w) >> (2 - l);
      t[anc-1] = (kid == 2 * anc);
    end
    return t;
  endfunction

  task automatic touch(int s, int w);
    @(negedge clk);
    upd_valid = 1; upd_set = 2'(s); upd_way = 3'(w);
    @(negedge clk);
    upd_valid = 0;
    mt[s] = mupd(mt[s], w);
  endtask

  task automatic sweep(int s);
    bit [7:0] smasks [4] = '{8'h00, 8'hC0, 8'h0F, 8'h81};
    lookup_set = 2'(s);
    for (int sm = 0; sm < 4; sm++)
      for (int sr = 0; sr < 256; sr++)
        for (int en = 0; en < 2; en++)
          for (int rq = 0; rq < 2; rq++) begin
            bit [7:0] cpu, io, e;
            int exp;
            string tag;
            sram_ways = 8'(sr); stash_ways = smasks[sm];
            stash_on = en[0]; req_stash = rq[0];
            cpu = ~8'(sr) & ~(en[0] ? smasks[sm] : 8'h00);
            io  = en[0] ? (smasks[sm] & ~8'(sr)) : cpu;
            e   = rq[0] ? io : cpu;
            exp = mvict(mt[s], e);
            #1;
            if (exp < 0) begin
              chk("R8 no_way", int'(no_way), 1);
              chk("R8 way0", int'(victim_way), 0);
            end else begin
              tag = !rq[0] ? "R2/R5 cpu victim" : (en[0] ? "R3/R5 stash victim" : "R4 stash-off victim");
              chk(tag, int'(victim_way), exp);
              chk("R9 no_way low", int'(no_way), 0);
            end
          end
    sram_ways = 0; stash_ways = 0; stash_on = 0; req_stash = 0;
  endtask

  initial begin
    int seq_way [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    int seq_exp [8] = '{4, 2, 6, 1, 5, 3, 7, 0};
    for (int s = 0; s < SETS; s++) mt[s] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state of every set
    for (int s = 0; s < SETS; s++) begin
      lookup_set = 2'(s); #1;
      chk("R1 reset victim", int'(victim_way), 0);
      chk("R1 reset no_way", int'(no_way), 0);
    end

    // R5: fixed access order gives known victims
    lookup_set = 0;
    for (int i = 0; i < 8; i++) begin
      touch(0, seq_way[i]);
      #1;
      chk("R5 sequence victim", int'(victim_way), seq_exp[i]);
    end

    // R7: other sets untouched
    lookup_set = 1; #1;
    chk("R7 set isolation", int'(victim_way), 0);

    // R6: strobe not visible in its own cycle, visible next cycle
    lookup_set = 1;
    @(negedge clk);
    upd_valid = 1; upd_set = 1; upd_way = 0;
    #1;
    chk("R6 same-cycle unchanged", int'(victim_way), 0);
    @(negedge clk);
    upd_valid = 0; mt[1] = mupd(mt[1], 0);
    #1;
    chk("R6 next-cycle victim", int'(victim_way), 4);

    // R2 R3 R4 R5 R8 R9: sweeps across many tree states
    sweep(0);
    for (int it = 0; it < 10; it++) begin
      for (int k = 0; k < 5; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        touch(int'(lfsr[4:3]), int'(lfsr[2:0]));
      end
      sweep(int'(lfsr[6:5]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule